// File: doc/BRIEF.md
# Descriptor Ring Engine

This block is the device half of a pair of descriptor rings shared with a host processor, one ring for transmit and one for receive. Every descriptor is a 32-bit word in a shared memory. A device-ownership flag in the word tells which side may touch it. The host fills descriptors, sets the flag and hands them over. The engine processes them and clears the flag to give them back.

On the transmit side, a wake-up command starts a walk from the current transmit index. Each device-owned descriptor is reported to the frame side as one frame with its byte count, rewritten with ownership cleared, and the index moves on. The walk stops at the first descriptor the host still holds.

On the receive side, each arriving frame is placed in the descriptor at the receive index, if the device owns it. The length written back counts four extra bytes for the frame check sequence. Sticky interrupt bits report returned descriptors. A channel reset command runs a timed sequence that clears indices and status and reports busy until it is done.

Top module: `ring_desc_engine`

## Requirements
- R1: Descriptor word layout: bit 31 = device owns, bit 30 = start of packet, bit 29 = end of packet, bits [LEN_W-1:0] = byte count (LEN_W defaults to 11). On transmit, bits outside the count have no effect on the frame length, and they come back unchanged in the rewritten word.
- R2: A wake-up (control write with bit 0 set) processes every consecutive device-owned transmit descriptor from the transmit index, in ring order. It emits one `tx_frame_o` pulse per descriptor, with `tx_len_o` equal to that descriptor's count field.
- R3: Each processed transmit descriptor is written back to its own address with bit 31 cleared and all other bits unchanged.
- R4: A wake-up that finds the descriptor at the transmit index host-owned emits no frame, writes nothing, sets no interrupt and leaves the transmit index unchanged.
- R5: The descriptor address is ring base plus index. Each index wraps from RING_SIZE-1 to 0 (RING_SIZE defaults to 16).
- R6: A receive frame that finds the descriptor at the receive index device-owned is accepted. The descriptor becomes bit 30 and bit 29 set, bit 31 clear, count = payload bytes + 4, all other bits zero, and the receive index advances.
- R7: A receive frame that finds its descriptor host-owned is dropped: `rx_ready_o` and `rx_drop_o` pulse together, memory is not written and the receive index does not move.
- R8: Status bit 0 (transmit) and bit 1 (receive) set when a descriptor of that ring is returned. They stay set until a status read, which clears them the following cycle; a new return in the read cycle wins.
- R9: A control write with bit 1 set aborts any walk and clears both indices, the status and any pending wake-up. It then holds `reset_busy_o` high for RST_CYCLES cycles, during which no memory access occurs and wake-ups are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctrl_we_i | input | 1 | Control command strobe |
| ctrl_wdata_i | input | 2 | Command bits: 0 = transmit wake-up, 1 = channel reset |
| reset_busy_o | output | 1 | Channel reset in progress |
| stat_rd_i | input | 1 | Status read strobe (clears status) |
| stat_o | output | 2 | Sticky status: 0 = transmit returned, 1 = receive returned |
| tx_base_i | input | ADDR_W | Transmit ring base address |
| rx_base_i | input | ADDR_W | Receive ring base address |
| mem_req_o | output | 1 | Descriptor memory access |
| mem_we_o | output | 1 | Access is a write |
| mem_addr_o | output | ADDR_W | Descriptor word address |
| mem_wdata_o | output | 32 | Write data |
| mem_rdata_i | input | 32 | Read data, one cycle after a read request |
| tx_frame_o | output | 1 | One transmit frame handed to the frame side |
| tx_len_o | output | LEN_W | Byte count of that frame |
| rx_valid_i | input | 1 | A received frame waits |
| rx_len_i | input | LEN_W | Its payload byte count, without check sequence |
| rx_ready_o | output | 1 | Frame taken (stored or dropped) |
| rx_drop_o | output | 1 | Frame dropped for lack of a descriptor |

## Verification
The assertions assume a memory that returns read data exactly one cycle after a read and never refuses an access. They assume the receive frame source holds `rx_valid_i` and `rx_len_i` steady until `rx_ready_o`, and that the two ring windows do not overlap. The bench memory model answers every read on the next edge. The frame source holds its request until it sees the ready pulse. Host descriptor writes happen only while the engine has no walk or frame in flight, and the rings sit at disjoint bases.

// File: rtl/ring_pkg.sv
// Shared constants and types for the descriptor ring engine.
// Assumes 32-bit descriptor words; the flag positions are decoded by host software.
package ring_pkg;
    localparam int DESC_W    = 32;
    localparam int OWN_BIT   = 31;
    localparam int SOP_BIT   = 30;
    localparam int EOP_BIT   = 29;
    localparam int FCS_BYTES = 4;
    localparam int CMD_WAKE  = 0;
    localparam int CMD_RESET = 1;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_TX_RD,
        ST_TX_CHK,
        ST_RX_RD,
        ST_RX_CHK
    } eng_state_t;
endpackage

// File: rtl/ring_index.sv
// Ring index counter: advances by one per returned descriptor and wraps at RING_SIZE.
// Assumes clr_i and inc_i are not needed together (clear wins).
module ring_index #(
    parameter int RING_SIZE = 16,
    localparam int IDX_W = (RING_SIZE > 1) ? $clog2(RING_SIZE) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             inc_i,
    output logic [IDX_W-1:0] idx_o
);
    logic [IDX_W-1:0] nxt;

    // Next index: a power-of-two ring wraps naturally, otherwise compare.
    generate
        if ((1 << IDX_W) == RING_SIZE) begin : g_pow2
            always_comb nxt = idx_o + 1'b1;
        end else begin : g_cmp
            always_comb nxt = (idx_o == IDX_W'(RING_SIZE - 1)) ? '0 : idx_o + 1'b1;
        end
    endgenerate

    // Index register.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) idx_o <= '0;
        else if (inc_i)      idx_o <= nxt;
    end
endmodule

// File: rtl/ring_status.sv
// Sticky transmit/receive return flags, cleared by a status read.
// A set arriving in the read cycle survives the clear.
module ring_status (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr_i,
    input  logic       tx_set_i,
    input  logic       rx_set_i,
    input  logic       rd_i,
    output logic [1:0] stat_o
);
    // Sticky flag update.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            stat_o <= '0;
        end else begin
            stat_o[0] <= tx_set_i | (stat_o[0] & ~rd_i);
            stat_o[1] <= rx_set_i | (stat_o[1] & ~rd_i);
        end
    end
endmodule

// File: rtl/ring_reset_seq.sv
// Channel reset sequencer: busy for RST_CYCLES cycles after a start strobe.
// A start during busy restarts the count.
module ring_reset_seq #(
    parameter int RST_CYCLES = 8,
    localparam int CNT_W = $clog2(RST_CYCLES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic busy_o
);
    logic [CNT_W-1:0] cnt;

    // Down counter that self-clears the busy indication.
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= '0;
        else if (start_i)    cnt <= CNT_W'(RST_CYCLES);
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign busy_o = (cnt != '0);
endmodule

// File: rtl/ring_desc_engine.sv
// Descriptor ring engine: device side of a transmit and a receive ring.
// Walks device-owned transmit descriptors on wake-up, stores received frames
// into device-owned receive descriptors, and returns each by clearing ownership.
// Assumes memory read data one cycle after a read and no back-pressure;
// receive has priority over transmit between descriptors.
module ring_desc_engine
    import ring_pkg::*;
#(
    parameter int RING_SIZE  = 16,
    parameter int ADDR_W     = 8,
    parameter int LEN_W      = 11,
    parameter int RST_CYCLES = 8,
    localparam int IDX_W = (RING_SIZE > 1) ? $clog2(RING_SIZE) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_we_i,
    input  logic [1:0]        ctrl_wdata_i,
    output logic              reset_busy_o,
    input  logic              stat_rd_i,
    output logic [1:0]        stat_o,
    input  logic [ADDR_W-1:0] tx_base_i,
    input  logic [ADDR_W-1:0] rx_base_i,
    output logic              mem_req_o,
    output logic              mem_we_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [DESC_W-1:0] mem_wdata_o,
    input  logic [DESC_W-1:0] mem_rdata_i,
    output logic              tx_frame_o,
    output logic [LEN_W-1:0]  tx_len_o,
    input  logic              rx_valid_i,
    input  logic [LEN_W-1:0]  rx_len_i,
    output logic              rx_ready_o,
    output logic              rx_drop_o
);
    eng_state_t       state;
    logic             tx_pend;
    logic             rst_cmd, wake_cmd, owned;
    logic             tx_hit, tx_miss, rx_hit, rx_miss;
    logic [IDX_W-1:0] tx_idx, rx_idx;
    logic [DESC_W-1:0] rx_word;

    // Command decode: reset wins over wake; wake is ignored while busy.
    assign rst_cmd  = ctrl_we_i & ctrl_wdata_i[CMD_RESET];
    assign wake_cmd = ctrl_we_i & ctrl_wdata_i[CMD_WAKE] & ~rst_cmd & ~reset_busy_o;
    assign owned    = mem_rdata_i[OWN_BIT];
    assign tx_hit   = (state == ST_TX_CHK) &  owned;
    assign tx_miss  = (state == ST_TX_CHK) & ~owned;
    assign rx_hit   = (state == ST_RX_CHK) &  owned;
    assign rx_miss  = (state == ST_RX_CHK) & ~owned;

    ring_reset_seq #(.RST_CYCLES(RST_CYCLES)) u_rst (
        .clk(clk), .rst_n(rst_n), .start_i(rst_cmd), .busy_o(reset_busy_o)
    );

    ring_index #(.RING_SIZE(RING_SIZE)) u_tx_idx (
        .clk(clk), .rst_n(rst_n), .clr_i(rst_cmd), .inc_i(tx_hit), .idx_o(tx_idx)
    );

    ring_index #(.RING_SIZE(RING_SIZE)) u_rx_idx (
        .clk(clk), .rst_n(rst_n), .clr_i(rst_cmd), .inc_i(rx_hit), .idx_o(rx_idx)
    );

    ring_status u_stat (
        .clk(clk), .rst_n(rst_n), .clr_i(rst_cmd), .tx_set_i(tx_hit),
        .rx_set_i(rx_hit), .rd_i(stat_rd_i), .stat_o(stat_o)
    );

    // Pending wake-up: set by command, dropped when the walk meets a host descriptor.
    always_ff @(posedge clk) begin
        if (!rst_n || rst_cmd) tx_pend <= 1'b0;
        else if (wake_cmd)     tx_pend <= 1'b1;
        else if (tx_miss)      tx_pend <= 1'b0;
    end

    // Access sequencer: read a descriptor, then test and return it.
    always_ff @(posedge clk) begin
        if (!rst_n || rst_cmd) begin
            state <= ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (reset_busy_o)    state <= ST_IDLE;
                    else if (rx_valid_i) state <= ST_RX_RD;
                    else if (tx_pend)    state <= ST_TX_RD;
                end
                ST_TX_RD:  state <= ST_TX_CHK;
                ST_RX_RD:  state <= ST_RX_CHK;
                default:   state <= ST_IDLE;
            endcase
        end
    end

    // Receive write-back word: start and end flags, count including check sequence.
    always_comb begin
        rx_word = '0;
        rx_word[SOP_BIT] = 1'b1;
        rx_word[EOP_BIT] = 1'b1;
        rx_word[LEN_W-1:0] = rx_len_i + LEN_W'(FCS_BYTES);
    end

    // Memory port drive.
    always_comb begin
        mem_req_o   = (state == ST_TX_RD) | (state == ST_RX_RD) | tx_hit | rx_hit;
        mem_we_o    = tx_hit | rx_hit;
        mem_addr_o  = ((state == ST_RX_RD) || (state == ST_RX_CHK))
                    ? rx_base_i + ADDR_W'(rx_idx)
                    : tx_base_i + ADDR_W'(tx_idx);
        mem_wdata_o = tx_hit ? (mem_rdata_i & ~(DESC_W'(1) << OWN_BIT)) : rx_word;
    end

    // Frame side outputs.
    assign tx_frame_o = tx_hit;
    assign tx_len_o   = mem_rdata_i[LEN_W-1:0];
    assign rx_ready_o = (state == ST_RX_CHK);
    assign rx_drop_o  = rx_miss;
endmodule

// File: rtl/ring_desc_engine_chk.sv
// Property checker for ring_desc_engine, attached by bind.
module ring_desc_engine_chk #(
    parameter int RING_SIZE = 16,
    parameter int ADDR_W    = 8,
    parameter int LEN_W     = 11
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ctrl_we_i,
    input logic [1:0]        ctrl_wdata_i,
    input logic              reset_busy_o,
    input logic              stat_rd_i,
    input logic [1:0]        stat_o,
    input logic [ADDR_W-1:0] tx_base_i,
    input logic [ADDR_W-1:0] rx_base_i,
    input logic              mem_req_o,
    input logic              mem_we_o,
    input logic [ADDR_W-1:0] mem_addr_o,
    input logic [31:0]       mem_wdata_o,
    input logic              tx_frame_o,
    input logic [LEN_W-1:0]  tx_len_o,
    input logic              rx_ready_o,
    input logic              rx_drop_o
);
    AST_WB_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we_o |-> (mem_req_o && !mem_wdata_o[31])); // R3
    AST_TX_FRAME_WB: assert property (@(posedge clk) disable iff (!rst_n)
        tx_frame_o |-> (mem_we_o && mem_wdata_o[LEN_W-1:0] == tx_len_o)); // R2
    AST_ADDR_IN_RING: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o |-> ((ADDR_W'(mem_addr_o - tx_base_i) < ADDR_W'(RING_SIZE)) ||
                       (ADDR_W'(mem_addr_o - rx_base_i) < ADDR_W'(RING_SIZE)))); // R5
    AST_RX_TAKE_XOR: assert property (@(posedge clk) disable iff (!rst_n)
        rx_ready_o |-> (mem_we_o != rx_drop_o)); // R7
    AST_DROP_NEEDS_READY: assert property (@(posedge clk) disable iff (!rst_n)
        rx_drop_o |-> rx_ready_o); // R7
    AST_STAT_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we_o && !(ctrl_we_i && ctrl_wdata_i[1])) |=> (stat_o != 2'b00)); // R8
    AST_STAT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd_i && !mem_we_o) |=> (stat_o == 2'b00)); // R8
    AST_BUSY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        reset_busy_o |-> !mem_req_o); // R9
    AST_RESET_CMD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_we_i && ctrl_wdata_i[1]) |=> (reset_busy_o && stat_o == 2'b00)); // R9
endmodule

bind ring_desc_engine ring_desc_engine_chk #(
    .RING_SIZE(RING_SIZE), .ADDR_W(ADDR_W), .LEN_W(LEN_W)
) chk_i (
    .clk(clk), .rst_n(rst_n), .ctrl_we_i(ctrl_we_i), .ctrl_wdata_i(ctrl_wdata_i),
    .reset_busy_o(reset_busy_o), .stat_rd_i(stat_rd_i), .stat_o(stat_o),
    .tx_base_i(tx_base_i), .rx_base_i(rx_base_i), .mem_req_o(mem_req_o),
    .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o),
    .tx_frame_o(tx_frame_o), .tx_len_o(tx_len_o), .rx_ready_o(rx_ready_o),
    .rx_drop_o(rx_drop_o)
);

// File: tb/ring_desc_engine_tb_top.sv
// Self-checking bench: host model, descriptor memory model, frame source and sink.
module ring_desc_engine_tb_top;
    localparam int RING  = 16;
    localparam int AW    = 8;
    localparam int LW    = 11;
    localparam int RSTC  = 8;
    localparam logic [31:0] OWN = 32'h8000_0000;
    localparam logic [31:0] SOP = 32'h4000_0000;
    localparam logic [31:0] EOP = 32'h2000_0000;
    localparam int BUFSZ = 1536;
    localparam logic [AW-1:0] TXB = 8'h10;
    localparam logic [AW-1:0] RXB = 8'h40;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ctrl_we = 1'b0;
    logic [1:0] ctrl_wd = '0;
    logic busy, stat_rd = 1'b0;
    logic [1:0] stat;
    logic mem_req, mem_we;
    logic [AW-1:0] mem_addr;
    logic [31:0] mem_wd, mem_rd = '0;
    logic tx_frame;
    logic [LW-1:0] tx_len;
    logic rx_valid = 1'b0;
    logic [LW-1:0] rx_len = '0;
    logic rx_ready, rx_drop;

    logic h_we = 1'b0;
    logic [AW-1:0] h_addr = '0;
    logic [31:0] h_wd = '0;
    logic [31:0] mem [0:255];

    int n_checks = 0, n_err = 0;
    int fr_cnt = 0;
    int fr_len [0:1023];
    int tx_i = 0, rx_i = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    ring_desc_engine #(.RING_SIZE(RING), .ADDR_W(AW), .LEN_W(LW), .RST_CYCLES(RSTC)) dut_i (
        .clk(clk), .rst_n(rst_n), .ctrl_we_i(ctrl_we), .ctrl_wdata_i(ctrl_wd),
        .reset_busy_o(busy), .stat_rd_i(stat_rd), .stat_o(stat),
        .tx_base_i(TXB), .rx_base_i(RXB), .mem_req_o(mem_req), .mem_we_o(mem_we),
        .mem_addr_o(mem_addr), .mem_wdata_o(mem_wd), .mem_rdata_i(mem_rd),
        .tx_frame_o(tx_frame), .tx_len_o(tx_len), .rx_valid_i(rx_valid),
        .rx_len_i(rx_len), .rx_ready_o(rx_ready), .rx_drop_o(rx_drop)
    );

    // Memory model: host port plus engine port, read data one cycle later.
    always @(posedge clk) begin
        if (h_we) mem[h_addr] <= h_wd;
        if (mem_req && mem_we) mem[mem_addr] <= mem_wd;
        if (mem_req && !mem_we) mem_rd <= mem[mem_addr];
    end

    // Frame sink: record every transmit frame length.
    always @(negedge clk) begin
        if (tx_frame) begin
            fr_len[fr_cnt] = int'(tx_len);
            fr_cnt = fr_cnt + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic post(input logic [AW-1:0] a, input logic [31:0] w);
        @(negedge clk); h_we = 1'b1; h_addr = a; h_wd = w;
        @(negedge clk); h_we = 1'b0;
    endtask

    task automatic ctrl(input logic [1:0] c);
        @(negedge clk); ctrl_we = 1'b1; ctrl_wd = c;
        @(negedge clk); ctrl_we = 1'b0; ctrl_wd = '0;
    endtask

    task automatic read_stat();
        @(negedge clk); stat_rd = 1'b1;
        @(negedge clk); stat_rd = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [AW-1:0] txa(input int i); return TXB + AW'(i); endfunction
    function automatic logic [AW-1:0] rxa(input int i); return RXB + AW'(i); endfunction
    function automatic logic [31:0] rx_expect(input int pl);
        return SOP | EOP | 32'(pl + 4);
    endfunction

    // Offer one receive frame; returns whether it was dropped.
    task automatic send_rx(input int pl, output bit dropped);
        int t;
        @(negedge clk); rx_valid = 1'b1; rx_len = LW'(pl);
        t = 0;
        dropped = 1'b0;
        while (!rx_ready && t < 50) begin @(negedge clk); t++; end
        dropped = rx_drop;
        chk(rx_ready == 1'b1, "R6 rx handshake", int'(rx_ready), 1);
        rx_valid = 1'b0;
        @(negedge clk);
    endtask

    // One transmit round of k posted descriptors.
    task automatic tx_round(input int k);
        logic [31:0] exp_w [0:15];
        int start;
        for (int j = 0; j < k; j++) begin
            exp_w[j] = OWN | SOP | EOP | ($urandom & 32'h1FFF_F800) | ($urandom & 32'h7FF);
            post(txa((tx_i + j) % RING), exp_w[j]);
        end
        start = fr_cnt;
        ctrl(2'b01);
        idle(6 * k + 10);
        chk(fr_cnt - start == k, "R2 frame count", fr_cnt - start, k);
        for (int j = 0; j < k; j++) begin
            chk(fr_len[start + j] == int'(exp_w[j][10:0]), "R2 R1 frame length",
                fr_len[start + j], int'(exp_w[j][10:0]));
            chk(mem[txa((tx_i + j) % RING)] == (exp_w[j] & ~OWN), "R3 tx write-back",
                int'(mem[txa((tx_i + j) % RING)]), int'(exp_w[j] & ~OWN));
        end
        tx_i = (tx_i + k) % RING;
        chk(stat[0] == 1'b1, "R8 tx status set", int'(stat), 1);
        read_stat();
        chk(stat == 2'b00, "R8 status cleared by read", int'(stat), 0);
    endtask

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_err++;
            n_checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
            $finish;
        end
    end

    initial begin
        bit dr;
        int pl, start, n;
        void'($urandom(32'd20240517));
        for (int i = 0; i < 256; i++) mem[i] = '0;
        idle(4);
        rst_n = 1'b1;
        @(negedge clk);
        chk(stat == 2'b00 && !busy && !tx_frame && !mem_req && !rx_ready,
            "R8 R9 reset state", int'({busy, tx_frame, mem_req, stat}), 0);

        // Transmit: full ring first, then random sizes that wrap (R5).
        tx_round(RING);
        for (int r = 0; r < 6; r++) tx_round(1 + int'($urandom % RING));

        // Wake with nothing device-owned (R4).
        start = fr_cnt;
        ctrl(2'b01);
        idle(20);
        chk(fr_cnt == start, "R4 no frame on empty wake", fr_cnt - start, 0);
        chk(stat == 2'b00, "R4 no status on empty wake", int'(stat), 0);
        tx_round(1);  // lands at the unchanged index (R4, R5)

        // Receive with random payloads (R6, R5 wrap).
        for (int r = 0; r < 4; r++) begin
            n = 1 + int'($urandom % 10);
            for (int j = 0; j < n; j++) post(rxa((rx_i + j) % RING), OWN | 32'(BUFSZ));
            for (int j = 0; j < n; j++) begin
                pl = 46 + int'($urandom % 1455);
                send_rx(pl, dr);
                chk(dr == 1'b0, "R6 frame not dropped", int'(dr), 0);
                chk(mem[rxa(rx_i)] == rx_expect(pl), "R6 rx write-back",
                    int'(mem[rxa(rx_i)]), int'(rx_expect(pl)));
                rx_i = (rx_i + 1) % RING;
            end
            chk(stat[1] == 1'b1, "R8 rx status set", int'(stat), 2);
            read_stat();
        end

        // Receive into a host-owned descriptor (R7).
        post(rxa(rx_i), 32'h0000_0123);
        read_stat();
        send_rx(100, dr);
        chk(dr == 1'b1, "R7 drop flagged", int'(dr), 1);
        chk(mem[rxa(rx_i)] == 32'h0000_0123, "R7 descriptor untouched",
            int'(mem[rxa(rx_i)]), 32'h123);
        chk(stat == 2'b00, "R7 no status on drop", int'(stat), 0);
        post(rxa(rx_i), OWN | 32'(BUFSZ));
        send_rx(60, dr);
        chk(mem[rxa(rx_i)] == rx_expect(60), "R7 index held after drop",
            int'(mem[rxa(rx_i)]), int'(rx_expect(60)));
        rx_i = (rx_i + 1) % RING;

        // Channel reset (R9): leave status set, post at slot 0, wake during busy.
        tx_round(3);
        post(rxa(0), OWN | 32'(BUFSZ));
        send_rx(70, dr);
        post(txa(0), OWN | SOP | EOP | 32'd77);
        start = fr_cnt;
        ctrl(2'b10);
        chk(busy == 1'b1, "R9 busy after reset", int'(busy), 1);
        chk(stat == 2'b00, "R9 status cleared", int'(stat), 0);
        ctrl(2'b01);
        n = 0;
        while (busy && n < 100) begin n++; @(negedge clk); end
        chk(n + 2 == RSTC, "R9 busy length", n + 2, RSTC);
        idle(20);
        chk(fr_cnt == start && mem[txa(0)][31], "R9 wake ignored while busy",
            fr_cnt - start, 0);
        ctrl(2'b01);
        idle(20);
        chk(fr_cnt - start == 1 && fr_len[start] == 77, "R9 tx index back to zero",
            fr_cnt - start, 1);
        chk(mem[txa(0)] == (SOP | EOP | 32'd77), "R9 R3 slot zero returned",
            int'(mem[txa(0)]), int'(SOP | EOP | 32'd77));
        post(rxa(0), OWN | 32'(BUFSZ));
        send_rx(90, dr);
        chk(mem[rxa(0)] == rx_expect(90), "R9 rx index back to zero",
            int'(mem[rxa(0)]), int'(rx_expect(90)));

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end
endmodule